// File: doc/BRIEF.md
# Masked Vector Gather/Scatter Unit

This block transfers vector elements between a vector register file and a word-addressed memory, one element per memory transaction. A single command selects one of three transfer kinds. An indexed load fetches the word at the base address plus the per-lane index into each lane. An indexed store writes each lane to the base address plus its index. A strided load fetches the word at the base address plus the lane number times a stride, which covers contiguous data (stride 1) and evenly spaced data.

A mask with one bit per lane, together with a vector length, selects the lanes that take part. Lanes are visited in ascending order, and idle lanes are skipped without spending cycles on them. An address at or above a command-supplied limit is invalid. The first participating lane with an invalid address ends the command, and the fault output reports its lane number. An invalid address on a lane that does not take part is never reported. The register file is reached through a combinational read port, addressed by `vrLane`, that returns the lane's index and source value, and through a write port used for loaded data.

Top module: `vec_gather_scatter`

## Requirements
- R1: With `cmdMode` 2'b00 (indexed load), every participating lane i gets the memory word at `cmdBase + index[i]` written into register lane i.
- R2: With `cmdMode` 2'b01 (indexed store), every participating lane i has its source value written to memory at `cmdBase + index[i]`.
- R3: With `cmdMode[1]` set (2'b10 and 2'b11 behave alike), every participating lane i gets the memory word at `cmdBase + i*cmdStride`. A stride of 0 and a stride of 1 are both legal.
- R4: A lane takes part only when its bit in `cmdMask` (bit i for lane i) is set and i < `cmdLen`. A lane that does not take part causes no memory request and no register write, so its register keeps its old value.
- R5: Lanes are handled in ascending order. When two participating store lanes share an address, the value from the higher lane is what remains in memory.
- R6: With `cmdWide` = 1, whole DATA_W-bit words move. With `cmdWide` = 0, a load writes the low half of the memory word, zero-extended, into the register. A store drives `memWide` low and places the low half of the source, zero-extended, on `memWdata`, and memory replaces only the low half of the word.
- R7: The address is computed at full precision, with no wrap-around. A participating lane whose address is at or above `cmdLimit` issues no request and ends the command. The completion pulse then comes with `fault` = 1 and `faultLane` = that lane. Earlier lanes are complete and later lanes are untouched.
- R8: An invalid address on a lane that does not take part never raises `fault`.
- R9: `done` is high for exactly one cycle, in the cycle after the last participating lane finishes. `fault` is high only together with `done`.
- R10: A command with `cmdLen` = 0, or with no mask bit set below `cmdLen`, raises `done` in the first cycle after acceptance and issues no memory request.
- R11: A command is accepted when `cmdValid` and `cmdReady` are both high. `cmdReady` is high only while idle, which includes right after reset. A memory request holds its address, direction and data until `memReady`. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Unit idle, command accepted |
| cmdMode | input | 2 | 00 indexed load, 01 indexed store, 1x strided load |
| cmdBase | input | ADDR_W | Common base word address |
| cmdStride | input | ADDR_W | Stride in words for strided load |
| cmdLen | input | VL_W | Vector length in lanes |
| cmdMask | input | LANES | Per-lane enable, bit i for lane i |
| cmdWide | input | 1 | 1 full word, 0 half word elements |
| cmdLimit | input | ADDR_W | Addresses at or above this value are invalid |
| vrLane | output | LANE_W | Lane selected on the register read port |
| vrIdx | input | ADDR_W | Index of lane `vrLane` |
| vrSrc | input | DATA_W | Source value of lane `vrLane` |
| vrWrEn | output | 1 | Register write strobe |
| vrWrLane | output | LANE_W | Register lane written |
| vrWrData | output | DATA_W | Register write data |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts request |
| memWrite | output | 1 | Request is a store |
| memWide | output | 1 | Store replaces the full word |
| memAddr | output | ADDR_W | Request word address |
| memWdata | output | DATA_W | Store data |
| memRvalid | input | 1 | Load response valid |
| memRdata | input | DATA_W | Load response data |
| done | output | 1 | Command completion pulse |
| fault | output | 1 | Completion ended on an invalid address |
| faultLane | output | LANE_W | Lane that faulted, valid with `fault` |

## Verification
The mask is swept over every value of an 8-lane setup, for both indexed loads and stores. This separates skipped lanes from handled ones and shows idle lanes costing no traffic. Store indices that collide across lanes show whether ascending order decides the final memory word. Strided loads run with strides 0, 1 and 3, both mode codes, and every length from 0 to 8, which tests the length cut-off and the lane-times-stride product. Fault cases use a low limit, an address sum that only exceeds the address width when carried, and the same invalid lanes with their mask bits cleared. These show the reported lane, that earlier lanes were kept, and that faults on idle lanes are suppressed.

// File: rtl/gs_pkg.sv
package gs_pkg;

  typedef enum logic [1:0] {
    MODE_GATHER     = 2'b00,
    MODE_SCATTER    = 2'b01,
    MODE_STRIDE     = 2'b10,
    MODE_STRIDE_ALT = 2'b11
  } gsMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchCmd;    // capture command, build pending-lane set
    logic latchLane;   // capture lane, address and store data
    logic retireLane;  // drop current lane from pending set
  } gsStrobe_t;

endpackage

// File: rtl/gs_datapath.sv
module gs_datapath
  import gs_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  localparam int LANE_W = $clog2(LANES),
  localparam int VL_W   = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  gsStrobe_t         strobe,
  input  logic [1:0]        cmdMode,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [ADDR_W-1:0] cmdStride,
  input  logic [VL_W-1:0]   cmdLen,
  input  logic [LANES-1:0]  cmdMask,
  input  logic              cmdWide,
  input  logic [ADDR_W-1:0] cmdLimit,
  output logic [LANE_W-1:0] vrLane,
  input  logic [ADDR_W-1:0] vrIdx,
  input  logic [DATA_W-1:0] vrSrc,
  output logic [LANE_W-1:0] vrWrLane,
  output logic [DATA_W-1:0] vrWrData,
  output logic              memWrite,
  output logic              memWide,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [LANE_W-1:0] faultLane,
  output logic              pendEmpty,
  output logic              addrBad,
  output logic              isWrite
);

  localparam int HALF_W = DATA_W / 2;
  localparam int SUM_W  = ADDR_W + LANE_W + 1;

  logic [ADDR_W-1:0] baseQ, strideQ, limitQ, addrQ;
  logic              wideQ, writeQ, strideModeQ;
  logic [LANES-1:0]  pendQ, lenMask;
  logic [LANE_W-1:0] laneQ, laneNext;
  logic [DATA_W-1:0] dataQ;
  logic [SUM_W-1:0]  addrSum;

  for (genvar g = 0; g < LANES; g++) begin : gLen
    assign lenMask[g] = (VL_W'(g) < cmdLen);
  end

  function automatic logic [LANE_W-1:0] lowestSet(input logic [LANES-1:0] v);
    lowestSet = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (v[i]) lowestSet = LANE_W'(i);
  endfunction

  assign laneNext  = lowestSet(pendQ);
  assign pendEmpty = (pendQ == '0);

  always_comb begin
    if (strideModeQ) addrSum = SUM_W'(baseQ) + SUM_W'(laneNext) * SUM_W'(strideQ);
    else             addrSum = SUM_W'(baseQ) + SUM_W'(vrIdx);
  end
  assign addrBad = (addrSum >= SUM_W'(limitQ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0; strideQ <= '0; limitQ <= '0; addrQ <= '0;
      wideQ <= 1'b0; writeQ <= 1'b0; strideModeQ <= 1'b0;
      pendQ <= '0; laneQ <= '0; dataQ <= '0;
    end else begin
      if (strobe.latchCmd) begin
        baseQ       <= cmdBase;
        strideQ     <= cmdStride;
        limitQ      <= cmdLimit;
        wideQ       <= cmdWide;
        writeQ      <= (cmdMode == MODE_SCATTER);
        strideModeQ <= cmdMode[1];
        pendQ       <= cmdMask & lenMask;
      end
      if (strobe.latchLane) begin
        laneQ <= laneNext;
        addrQ <= addrSum[ADDR_W-1:0];
        dataQ <= wideQ ? vrSrc : {{HALF_W{1'b0}}, vrSrc[HALF_W-1:0]};
      end
      if (strobe.retireLane) pendQ[laneQ] <= 1'b0;
    end
  end

  assign vrLane    = laneNext;
  assign faultLane = laneNext;
  assign vrWrLane  = laneQ;
  assign vrWrData  = wideQ ? memRdata : {{HALF_W{1'b0}}, memRdata[HALF_W-1:0]};
  assign memWrite  = writeQ;
  assign memWide   = wideQ;
  assign memAddr   = addrQ;
  assign memWdata  = dataQ;
  assign isWrite   = writeQ;

endmodule

// File: rtl/gs_control.sv
module gs_control
  import gs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  output logic      cmdReady,
  input  logic      pendEmpty,
  input  logic      addrBad,
  input  logic      isWrite,
  output logic      memValid,
  input  logic      memReady,
  input  logic      memRvalid,
  output logic      vrWrEn,
  output logic      done,
  output logic      fault,
  output gsStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_PICK, ST_REQ, ST_WAIT} gsState_e;
  gsState_e stateQ, stateD;

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    cmdReady = 1'b0;
    memValid = 1'b0;
    vrWrEn   = 1'b0;
    done     = 1'b0;
    fault    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        cmdReady = 1'b1;
        if (cmdValid) begin
          strobe.latchCmd = 1'b1;
          stateD = ST_PICK;
        end
      end
      ST_PICK: begin
        if (pendEmpty) begin
          done   = 1'b1;
          stateD = ST_IDLE;
        end else if (addrBad) begin
          done   = 1'b1;
          fault  = 1'b1;
          stateD = ST_IDLE;
        end else begin
          strobe.latchLane = 1'b1;
          stateD = ST_REQ;
        end
      end
      ST_REQ: begin
        memValid = 1'b1;
        if (memReady) begin
          if (isWrite) begin
            strobe.retireLane = 1'b1;
            stateD = ST_PICK;
          end else begin
            stateD = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (memRvalid) begin
          vrWrEn = 1'b1;
          strobe.retireLane = 1'b1;
          stateD = ST_PICK;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/vec_gather_scatter.sv
module vec_gather_scatter
  import gs_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  localparam int LANE_W = $clog2(LANES),
  localparam int VL_W   = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdMode,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic [ADDR_W-1:0] cmdStride,
  input  logic [VL_W-1:0]   cmdLen,
  input  logic [LANES-1:0]  cmdMask,
  input  logic              cmdWide,
  input  logic [ADDR_W-1:0] cmdLimit,
  output logic [LANE_W-1:0] vrLane,
  input  logic [ADDR_W-1:0] vrIdx,
  input  logic [DATA_W-1:0] vrSrc,
  output logic              vrWrEn,
  output logic [LANE_W-1:0] vrWrLane,
  output logic [DATA_W-1:0] vrWrData,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic              memWide,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memRvalid,
  input  logic [DATA_W-1:0] memRdata,
  output logic              done,
  output logic              fault,
  output logic [LANE_W-1:0] faultLane
);

  gsStrobe_t strobe;
  logic      pendEmpty, addrBad, isWrite;

  gs_control u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .pendEmpty(pendEmpty), .addrBad(addrBad), .isWrite(isWrite),
    .memValid(memValid), .memReady(memReady), .memRvalid(memRvalid),
    .vrWrEn(vrWrEn), .done(done), .fault(fault), .strobe(strobe)
  );

  gs_datapath #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdMode(cmdMode), .cmdBase(cmdBase), .cmdStride(cmdStride), .cmdLen(cmdLen),
    .cmdMask(cmdMask), .cmdWide(cmdWide), .cmdLimit(cmdLimit),
    .vrLane(vrLane), .vrIdx(vrIdx), .vrSrc(vrSrc),
    .vrWrLane(vrWrLane), .vrWrData(vrWrData),
    .memWrite(memWrite), .memWide(memWide), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .faultLane(faultLane),
    .pendEmpty(pendEmpty), .addrBad(addrBad), .isWrite(isWrite)
  );

endmodule

// File: rtl/gs_checker.sv
module gs_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdReady,
  input logic              memValid,
  input logic              memReady,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              vrWrEn,
  input logic              done,
  input logic              fault
);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memWrite) && $stable(memWdata));

  assert_busy_no_cmd_R11: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !cmdReady);

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rstN)
    vrWrEn |-> !memValid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_fault_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> done);

  assert_no_req_at_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memValid && !vrWrEn);

endmodule

bind vec_gather_scatter gs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .memValid(memValid),
  .memReady(memReady), .memWrite(memWrite), .memAddr(memAddr),
  .memWdata(memWdata), .vrWrEn(vrWrEn), .done(done), .fault(fault)
);

// File: tb/vec_gather_scatter_bench.sv
`timescale 1ns/1ps
module vec_gather_scatter_bench;

  localparam int LANES = 8, ADDR_W = 8, DATA_W = 64;
  localparam int LANE_W = 3, VL_W = 4, MEMD = 256;

  logic clk = 1'b0, rstN = 1'b0;
  always #5 clk = ~clk;

  logic              cmdValid = 1'b0, cmdReady, cmdWide = 1'b1;
  logic [1:0]        cmdMode = 2'b00;
  logic [ADDR_W-1:0] cmdBase = '0, cmdStride = '0, cmdLimit = '0;
  logic [VL_W-1:0]   cmdLen = '0;
  logic [LANES-1:0]  cmdMask = '0;
  logic [LANE_W-1:0] vrLane, vrWrLane, faultLane;
  logic [ADDR_W-1:0] vrIdx, memAddr;
  logic [DATA_W-1:0] vrSrc, vrWrData, memWdata;
  logic [DATA_W-1:0] memRdata = '0;
  logic              vrWrEn, memValid, memReady, memWrite, memWide, done, fault;
  logic              memRvalid = 1'b0;

  logic [DATA_W-1:0] mem [MEMD];
  logic [DATA_W-1:0] vr [LANES];
  logic [ADDR_W-1:0] idxArr [LANES];
  logic [7:0]        rdyCnt = '0;
  int                accCount = 0;
  logic              presetReq = 1'b0;
  int                presetSeed = 0;

  int total = 0, bad = 0, seed = 0;

  vec_gather_scatter #(.LANES(LANES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_vec_gather_scatter (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdMode(cmdMode),
    .cmdBase(cmdBase), .cmdStride(cmdStride), .cmdLen(cmdLen), .cmdMask(cmdMask),
    .cmdWide(cmdWide), .cmdLimit(cmdLimit), .vrLane(vrLane), .vrIdx(vrIdx), .vrSrc(vrSrc),
    .vrWrEn(vrWrEn), .vrWrLane(vrWrLane), .vrWrData(vrWrData), .memValid(memValid),
    .memReady(memReady), .memWrite(memWrite), .memWide(memWide), .memAddr(memAddr),
    .memWdata(memWdata), .memRvalid(memRvalid), .memRdata(memRdata), .done(done),
    .fault(fault), .faultLane(faultLane)
  );

  function automatic logic [63:0] memInit(int a, int s);
    return {8'(s), 24'(a * 131 + 5), 32'(a * 7 + s * 3 + 1)};
  endfunction
  function automatic logic [63:0] vrInit(int i, int s);
    return {16'hC0DE, 16'(i), 32'(s * 17 + i * 5 + 2) | 32'h8000_0000};
  endfunction

  assign vrIdx    = idxArr[vrLane];
  assign vrSrc    = vr[vrLane];
  assign memReady = (rdyCnt[1:0] != 2'd0);

  // Memory and register-file model
  always @(posedge clk) begin
    rdyCnt    <= rdyCnt + 8'd1;
    memRvalid <= 1'b0;
    if (presetReq) begin
      for (int a = 0; a < MEMD; a++) mem[a] <= memInit(a, presetSeed);
      for (int i = 0; i < LANES; i++) vr[i] <= vrInit(i, presetSeed);
    end
    if (memValid && memReady) begin
      accCount <= accCount + 1;
      if (memWrite)
        mem[memAddr] <= memWide ? memWdata : {mem[memAddr][63:32], memWdata[31:0]};
      else begin
        memRvalid <= 1'b1;
        memRdata  <= mem[memAddr];
      end
    end
    if (vrWrEn) vr[vrWrLane] <= vrWrData;
  end

  task automatic check(bit ok, string tag, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  logic [63:0] expMem [MEMD];
  logic [63:0] expVr [LANES];

  task automatic runCase(string tag, logic [1:0] mode, int base, int stride, int len,
                         logic [7:0] mask, bit wide, int limit);
    bit expFault = 0;
    int expLane = 0, expAcc = 0, cyc, accStart, addr, memBad, vrBad;
    bit gotFault;
    int gotLane;
    longint unsigned firstAct, firstExp;
    seed++;
    @(negedge clk);
    presetSeed = seed; presetReq = 1'b1;
    @(negedge clk);
    presetReq = 1'b0;
    for (int a = 0; a < MEMD; a++) expMem[a] = memInit(a, seed);
    for (int i = 0; i < LANES; i++) expVr[i] = vrInit(i, seed);
    for (int i = 0; i < LANES; i++) begin
      if (mask[i] && i < len) begin
        addr = mode[1] ? base + i * stride : base + int'(idxArr[i]);
        if (addr >= limit) begin expFault = 1; expLane = i; break; end
        expAcc++;
        if (mode == 2'b01)
          expMem[addr] = wide ? expVr[i] : {expMem[addr][63:32], expVr[i][31:0]};
        else
          expVr[i] = wide ? expMem[addr] : {32'd0, expMem[addr][31:0]};
      end
    end
    while (!cmdReady) @(negedge clk);
    accStart = accCount;
    cmdValid = 1'b1; cmdMode = mode; cmdBase = 8'(base); cmdStride = 8'(stride);
    cmdLen = 4'(len); cmdMask = mask; cmdWide = wide; cmdLimit = 8'(limit);
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    cyc = 1;
    while (!done && cyc < 400) begin @(negedge clk); cyc++; end
    gotFault = fault; gotLane = int'(faultLane);
    check(done, tag, "done seen", longint'(cyc), 0);
    check(gotFault == expFault && (!expFault || gotLane == expLane), expFault ? "R7" : "R8",
          "fault/lane", {gotFault, 8'(gotLane)}, {expFault, 8'(expLane)});
    @(negedge clk);
    check(!done, "R9", "done one cycle", 64'(done), 0);
    memBad = 0; vrBad = 0; firstAct = 0; firstExp = 0;
    for (int a = 0; a < MEMD; a++)
      if (mem[a] !== expMem[a]) begin
        if (memBad == 0) begin firstAct = mem[a]; firstExp = expMem[a]; end
        memBad++;
      end
    check(memBad == 0, tag, "memory contents", firstAct, firstExp);
    firstAct = 0; firstExp = 0;
    for (int i = 0; i < LANES; i++)
      if (vr[i] !== expVr[i]) begin
        if (vrBad == 0) begin firstAct = vr[i]; firstExp = expVr[i]; end
        vrBad++;
      end
    check(vrBad == 0, tag, "register contents", firstAct, firstExp);
    check(accCount - accStart == expAcc, "R4", "memory request count",
          longint'(accCount - accStart), longint'(expAcc));
    if (expAcc == 0 && !expFault)
      check(cyc == 1, "R10", "cycles to done", longint'(cyc), 1);
  endtask

  initial begin
    for (int i = 0; i < LANES; i++) idxArr[i] = 8'(i * 5 + 3);
    repeat (3) @(negedge clk);
    // R11: idle state out of reset
    check(cmdReady && !memValid && !done && !fault, "R11", "reset state",
          {cmdReady, memValid, done, fault}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdReady && !memValid && !done, "R11", "idle after reset",
          {cmdReady, memValid, done}, 3'b100);

    runCase("R1", 2'b00, 10, 0, 8, 8'hFF, 1'b1, 255);
    runCase("R6", 2'b00, 10, 0, 8, 8'hFF, 1'b0, 255);
    runCase("R4", 2'b00, 10, 0, 8, 8'b1011_0010, 1'b1, 255);
    runCase("R4", 2'b00, 10, 0, 5, 8'hFF, 1'b1, 255);
    runCase("R2", 2'b01, 30, 0, 8, 8'hFF, 1'b1, 255);
    runCase("R6", 2'b01, 30, 0, 8, 8'hFF, 1'b0, 255);
    // R7: lane 6 lands at 43, at or above limit 40
    runCase("R7", 2'b00, 10, 0, 8, 8'hFF, 1'b1, 40);
    runCase("R7", 2'b01, 10, 0, 8, 8'hFF, 1'b1, 40);
    // R8: invalid lanes 6 and 7 masked off
    runCase("R8", 2'b00, 10, 0, 8, 8'b0011_1111, 1'b1, 40);
    runCase("R8", 2'b01, 10, 0, 8, 8'b0011_1111, 1'b0, 40);
    // R10: zero length and empty mask
    runCase("R10", 2'b00, 10, 0, 0, 8'hFF, 1'b1, 255);
    runCase("R10", 2'b01, 10, 0, 8, 8'h00, 1'b1, 255);
    runCase("R10", 2'b00, 10, 0, 3, 8'hF8, 1'b1, 0);

    // R5: colliding store indices
    for (int i = 0; i < LANES; i++) idxArr[i] = 8'(i % 3);
    runCase("R5", 2'b01, 50, 0, 8, 8'hFF, 1'b1, 255);
    runCase("R5", 2'b01, 50, 0, 8, 8'b0110_1101, 1'b1, 255);

    // R7: full-precision sum, 250 + 10 wraps in 8 bits but still faults
    for (int i = 0; i < LANES; i++) idxArr[i] = 8'(i == 2 ? 10 : 1);
    runCase("R7", 2'b00, 250, 0, 8, 8'hFF, 1'b1, 255);
    runCase("R7", 2'b10, 200, 10, 8, 8'hFF, 1'b1, 255);

    // R3: strided loads, several strides and both mode codes, every length
    runCase("R3", 2'b10, 20, 1, 8, 8'hFF, 1'b1, 255);
    runCase("R3", 2'b10, 20, 3, 8, 8'hFF, 1'b1, 255);
    runCase("R3", 2'b10, 20, 0, 8, 8'b1010_0101, 1'b0, 255);
    runCase("R3", 2'b11, 7, 2, 8, 8'hFF, 1'b1, 255);
    for (int n = 0; n <= LANES; n++) runCase("R3", 2'b10, 40, 5, n, 8'hFF, 1'b1, 255);

    // R1/R2/R4: every mask value, indexed load and store
    for (int i = 0; i < LANES; i++) idxArr[i] = 8'(i * 9 + 1);
    for (int m = 0; m < 256; m++) begin
      runCase("R1", 2'b00, 5, 0, 8, 8'(m), m[0], 255);
      runCase("R2", 2'b01, 5, 0, 8, 8'(m), m[1], 255);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule